// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block turns a held group of input events into a timed system reset. A host-side scanner presents one active bit per event code on a wide bus. Each of two independent channels holds a small set of event-code slots. When every slot in use on a channel sees its event active, and the group stays active for a selectable qualification time, the channel drives an active-low reset pulse of selectable width on its own output. Channel one has three slots and channel two has two.

Both durations are counted in ticks of an external timebase. The qualification time is a 3-bit selector shared by the two channels, and code k means k hold units (the default unit is one second). The pulse width is a 2-bit selector, and code p means 2^p pulse units (the default unit is half a millisecond). An enable can also route an active-low external reset onto the channel-one output, alongside the generated pulse. That gives a way to reset a locked-up system without cutting its power.

Top module: `kcr_rst_gen`

## Requirements
- R1: After reset both outputs `rst1_n` and `rst2_n` are high (inactive).
- R2: A channel can start a pulse only while, for every slot holding a nonzero code c, bit c of `evt_active` is 1; if any such bit is 0 the output stays high however many ticks pass.
- R3: A slot holding code 0 is unused and counts as satisfied; a channel whose slots all hold 0 never pulses, even with every event bit set.
- R4: With hold selector k > 0, the channel needs k*HOLD_UNIT ticks while its combination is satisfied; its output falls on the first clock edge after the edge that samples the last of those ticks.
- R5: With hold selector 0 the output falls on the first clock edge at which the combination is satisfied.
- R6: If the combination stops being satisfied for even one clock before the count completes, the tick count restarts from zero.
- R7: The pulse lasts (2^p)*PULSE_UNIT ticks for width selector p; the output rises on the edge that samples the last of them, and never rises on an edge without a tick.
- R8: A combination held past its pulse gives only one pulse; after one required event is released and the combination is formed again, the channel can pulse again.
- R9: While `cfg_pass_en` is 1, a low `ext_rst_n` forces `rst1_n` low in the same cycle (combinational); while `cfg_pass_en` is 0, `ext_rst_n` has no effect on `rst1_n`.
- R10: The channels are independent: a pulse on one leaves the other output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| evt_active | input | 2**CODE_W | One active bit per event code |
| ch1_codes | input | CH1_SLOTS*CODE_W | Channel-one slot codes, slot 0 in the low bits |
| ch2_codes | input | CH2_SLOTS*CODE_W | Channel-two slot codes, slot 0 in the low bits |
| cfg_hold_sel | input | 3 | Qualification time selector (shared) |
| cfg_pw_sel | input | 2 | Pulse width selector (shared) |
| cfg_pass_en | input | 1 | Route ext_rst_n onto rst1_n |
| ext_rst_n | input | 1 | External active-low reset input |
| rst1_n | output | 1 | Channel-one reset, active low |
| rst2_n | output | 1 | Channel-two reset, active low |

## Verification
The pass-through is combinational, so its effect is checked one time step after the input changes. A generated pulse starts one edge after qualification: for the immediate setting that is the first edge at which the combination is satisfied, and otherwise it is the edge after the final hold tick. The pulse ends on the edge that samples its last tick. The bench drives every input on the falling edge. Its tick task spends one clock with the strobe high and one clock with it low. So the counts of ticks before and after each transition are known exactly: the output is checked one tick short of the transition and again right after it.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

   localparam int unsigned HOLD_SEL_W = 3;
   localparam int unsigned PW_SEL_W   = 2;

   // qualification length in ticks: selector times the hold unit
   function automatic int unsigned hold_ticks(input logic [HOLD_SEL_W-1:0] sel,
                                              input int unsigned unit);
      return int'(sel) * unit;
   endfunction

   // pulse length in ticks: power of two of the selector times the pulse unit
   function automatic int unsigned pulse_ticks(input logic [PW_SEL_W-1:0] sel,
                                               input int unsigned unit);
      return (32'd1 << sel) * unit;
   endfunction

endpackage

// File: rtl/kcr_match.sv
module kcr_match #(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned NSLOTS = 3,
   localparam int unsigned NCODES = 1 << CODE_W
) (
   input  logic [NSLOTS*CODE_W-1:0] codes,
   input  logic [NCODES-1:0]        evt_active,
   output logic                     sat
);

   logic [NSLOTS-1:0] used;
   logic [NSLOTS-1:0] ok;

   for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      logic [CODE_W-1:0] code;
      assign code    = codes[s*CODE_W +: CODE_W];
      assign used[s] = |code;
      assign ok[s]   = !used[s] || evt_active[code];
   end

   // a channel with no used slot is never satisfied
   assign sat = (|used) && (&ok);

endmodule

// File: rtl/kcr_hold.sv
module kcr_hold #(
   parameter int unsigned HOLD_UNIT = 2000,
   localparam int unsigned HW = $clog2(7 * HOLD_UNIT + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic                            sat,
   input  logic [kcr_pkg::HOLD_SEL_W-1:0]  hold_sel,
   output logic                            fire
);

   logic          armed;
   logic [HW-1:0] cnt;
   logic [HW-1:0] target;

   assign target = HW'(kcr_pkg::hold_ticks(hold_sel, HOLD_UNIT));
   assign fire   = sat && armed && (cnt >= target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else begin
         if (!sat)
            armed <= 1'b1;
         else if (fire)
            armed <= 1'b0;

         if (!sat || !armed || fire)
            cnt <= '0;
         else if (tick && (cnt < target))
            cnt <= cnt + HW'(1);
      end
   end

endmodule

// File: rtl/kcr_pulse.sv
module kcr_pulse #(
   parameter int unsigned PULSE_UNIT = 1,
   localparam int unsigned PW = $clog2(8 * PULSE_UNIT + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic                          fire,
   input  logic [kcr_pkg::PW_SEL_W-1:0]  pw_sel,
   output logic                          out_n
);

   logic [PW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (fire)
         left <= PW'(kcr_pkg::pulse_ticks(pw_sel, PULSE_UNIT));
      else if (tick && (left != '0))
         left <= left - PW'(1);
   end

   assign out_n = (left == '0);

endmodule

// File: rtl/kcr_channel.sv
module kcr_channel #(
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned NSLOTS     = 3,
   parameter int unsigned HOLD_UNIT  = 2000,
   parameter int unsigned PULSE_UNIT = 1,
   localparam int unsigned NCODES = 1 << CODE_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic [NCODES-1:0]               evt_active,
   input  logic [NSLOTS*CODE_W-1:0]        codes,
   input  logic [kcr_pkg::HOLD_SEL_W-1:0]  hold_sel,
   input  logic [kcr_pkg::PW_SEL_W-1:0]    pw_sel,
   output logic                            gen_n
);

   logic sat;
   logic fire;

   kcr_match #(.CODE_W(CODE_W), .NSLOTS(NSLOTS)) u_match (
      .codes(codes), .evt_active(evt_active), .sat(sat)
   );

   kcr_hold #(.HOLD_UNIT(HOLD_UNIT)) u_hold (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sat(sat),
      .hold_sel(hold_sel), .fire(fire)
   );

   kcr_pulse #(.PULSE_UNIT(PULSE_UNIT)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fire(fire),
      .pw_sel(pw_sel), .out_n(gen_n)
   );

endmodule

// File: rtl/kcr_rst_gen.sv
module kcr_rst_gen #(
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned CH1_SLOTS  = 3,
   parameter int unsigned CH2_SLOTS  = 2,
   parameter int unsigned HOLD_UNIT  = 2000,
   parameter int unsigned PULSE_UNIT = 1,
   localparam int unsigned NCODES = 1 << CODE_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic [NCODES-1:0]               evt_active,
   input  logic [CH1_SLOTS*CODE_W-1:0]     ch1_codes,
   input  logic [CH2_SLOTS*CODE_W-1:0]     ch2_codes,
   input  logic [kcr_pkg::HOLD_SEL_W-1:0]  cfg_hold_sel,
   input  logic [kcr_pkg::PW_SEL_W-1:0]    cfg_pw_sel,
   input  logic                            cfg_pass_en,
   input  logic                            ext_rst_n,
   output logic                            rst1_n,
   output logic                            rst2_n
);

   if (CODE_W < 1 || CODE_W > 10) begin : g_bad_code_w
      $error("kcr_rst_gen: CODE_W out of range");
   end
   if (CH1_SLOTS < 1 || CH2_SLOTS < 1) begin : g_bad_slots
      $error("kcr_rst_gen: each channel needs a slot");
   end
   if (HOLD_UNIT < 1 || PULSE_UNIT < 1) begin : g_bad_unit
      $error("kcr_rst_gen: tick units must be nonzero");
   end

   logic gen1_n;

   kcr_channel #(.CODE_W(CODE_W), .NSLOTS(CH1_SLOTS),
                 .HOLD_UNIT(HOLD_UNIT), .PULSE_UNIT(PULSE_UNIT)) u_ch1 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_active(evt_active),
      .codes(ch1_codes), .hold_sel(cfg_hold_sel), .pw_sel(cfg_pw_sel),
      .gen_n(gen1_n)
   );

   kcr_channel #(.CODE_W(CODE_W), .NSLOTS(CH2_SLOTS),
                 .HOLD_UNIT(HOLD_UNIT), .PULSE_UNIT(PULSE_UNIT)) u_ch2 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_active(evt_active),
      .codes(ch2_codes), .hold_sel(cfg_hold_sel), .pw_sel(cfg_pw_sel),
      .gen_n(rst2_n)
   );

   // external reset merges onto channel one only when enabled
   assign rst1_n = gen1_n & (ext_rst_n | ~cfg_pass_en);

endmodule

// File: rtl/kcr_checker.sv
module kcr_checker #(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned CH2_SLOTS = 2,
   localparam int unsigned NCODES = 1 << CODE_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tick,
   input logic [NCODES-1:0]           evt_active,
   input logic [CH2_SLOTS*CODE_W-1:0] ch2_codes,
   input logic                        cfg_pass_en,
   input logic                        ext_rst_n,
   input logic                        rst1_n,
   input logic                        rst2_n
);

   logic ch2_ok;
   always_comb begin
      logic any_used;
      any_used = 1'b0;
      ch2_ok   = 1'b1;
      for (int s = 0; s < int'(CH2_SLOTS); s++) begin
         if (ch2_codes[s*CODE_W +: CODE_W] != '0) begin
            any_used = 1'b1;
            if (!evt_active[ch2_codes[s*CODE_W +: CODE_W]]) ch2_ok = 1'b0;
         end
      end
      ch2_ok = ch2_ok && any_used;
   end

   a_r9_pass_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pass_en && !ext_rst_n) |-> !rst1_n);

   a_r3_blank_channel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ch2_codes == '0 && rst2_n) |=> rst2_n);

   a_r2_fall_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst2_n) |-> $past(ch2_ok));

   a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst2_n) |-> $past(tick));

endmodule

bind kcr_rst_gen kcr_checker #(.CODE_W(CODE_W), .CH2_SLOTS(CH2_SLOTS)) u_kcr_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .evt_active(evt_active),
   .ch2_codes(ch2_codes), .cfg_pass_en(cfg_pass_en), .ext_rst_n(ext_rst_n),
   .rst1_n(rst1_n), .rst2_n(rst2_n)
);

// File: tb/test_kcr_rst_gen.sv
module test_kcr_rst_gen;

   localparam int unsigned HU = 4;
   localparam int unsigned PU = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [255:0] evt = '0;
   logic [23:0]  c1 = '0;
   logic [15:0]  c2 = '0;
   logic [2:0]   hsel = '0;
   logic [1:0]   psel = '0;
   logic         pass_en = 1'b0;
   logic         ext_n = 1'b1;
   logic         rst1_n, rst2_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   kcr_rst_gen #(.HOLD_UNIT(HU), .PULSE_UNIT(PU)) i_kcr_rst_gen (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_active(evt),
      .ch1_codes(c1), .ch2_codes(c2), .cfg_hold_sel(hsel), .cfg_pw_sel(psel),
      .cfg_pass_en(pass_en), .ext_rst_n(ext_n), .rst1_n(rst1_n), .rst2_n(rst2_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one clock with strobe high, one clock low
   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R1 rst1_n after reset", rst1_n, 1'b1);
      chk("R1 rst2_n after reset", rst2_n, 1'b1);
   endtask

   task automatic t_hold_and_width;
      hsel = 3'd2; psel = 2'd1;             // 8 ticks hold, 4 ticks pulse
      c1 = {8'h56, 8'h34, 8'h12};
      evt[8'h12] = 1'b1; evt[8'h34] = 1'b1;
      ticks(10);
      chk("R2 partial combination", rst1_n, 1'b1);
      evt[8'h56] = 1'b1;
      ticks(7);
      chk("R4 one tick short", rst1_n, 1'b1);
      ticks(1);
      chk("R4 fall after last hold tick", rst1_n, 1'b0);
      chk("R10 other channel idle", rst2_n, 1'b1);
      ticks(3);
      chk("R7 still low one tick short", rst1_n, 1'b0);
      cycles(3);
      chk("R7 no release without tick", rst1_n, 1'b0);
      ticks(1);
      chk("R7 release after width", rst1_n, 1'b1);
   endtask

   task automatic t_single_pulse;
      ticks(20);
      chk("R8 held combination one pulse", rst1_n, 1'b1);
      evt[8'h34] = 1'b0;
      cycles(1);
      evt[8'h34] = 1'b1;
      ticks(8);
      chk("R8 rearmed after release", rst1_n, 1'b0);
      ticks(4);
      chk("R8 second pulse done", rst1_n, 1'b1);
      evt = '0;
      cycles(1);
   endtask

   task automatic t_dropout;
      hsel = 3'd1; psel = 2'd0;             // 4 ticks hold, 2 ticks pulse
      c2 = {8'h43, 8'h21};
      evt[8'h21] = 1'b1; evt[8'h43] = 1'b1;
      ticks(3);
      evt[8'h43] = 1'b0;
      cycles(1);
      evt[8'h43] = 1'b1;
      ticks(3);
      chk("R6 count restarted", rst2_n, 1'b1);
      ticks(1);
      chk("R6 fires after full hold", rst2_n, 1'b0);
      chk("R10 channel one unaffected", rst1_n, 1'b1);
      ticks(2);
      chk("R7 two tick pulse done", rst2_n, 1'b1);
      evt = '0;
      cycles(1);
   endtask

   task automatic t_immediate;
      hsel = 3'd0; psel = 2'd0;
      cycles(1);
      evt[8'h21] = 1'b1; evt[8'h43] = 1'b1;
      cycles(1);
      chk("R5 immediate fall", rst2_n, 1'b0);
      chk("R10 channel one idle", rst1_n, 1'b1);
      ticks(2);
      chk("R5 pulse ends", rst2_n, 1'b1);
      evt = '0;
      cycles(1);
   endtask

   task automatic t_unused;
      hsel = 3'd0; psel = 2'd0;
      c1 = {8'h00, 8'h00, 8'h77};
      cycles(1);
      evt[8'h77] = 1'b1;
      cycles(1);
      chk("R3 zero slots satisfied", rst1_n, 1'b0);
      ticks(2);
      evt = '0;
      cycles(1);
      c1 = '0; c2 = '0;
      evt = '1;
      cycles(1);
      ticks(5);
      chk("R3 blank channel one quiet", rst1_n, 1'b1);
      chk("R3 blank channel two quiet", rst2_n, 1'b1);
      evt = '0;
      cycles(1);
   endtask

   task automatic t_pass;
      pass_en = 1'b0; ext_n = 1'b0;
      #1;
      chk("R9 disabled ignores ext", rst1_n, 1'b1);
      cycles(2);
      chk("R9 disabled still high", rst1_n, 1'b1);
      pass_en = 1'b1;
      #1;
      chk("R9 pass-through low", rst1_n, 1'b0);
      chk("R10 pass-through not on ch2", rst2_n, 1'b1);
      ext_n = 1'b1;
      #1;
      chk("R9 pass-through released", rst1_n, 1'b1);
      pass_en = 1'b0;
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      t_reset();
      t_hold_and_width();
      t_single_pulse();
      t_dropout();
      t_immediate();
      t_unused();
      t_pass();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule